// File: doc/BRIEF.md
# Bus access watchpoint unit

This block watches every access on a memory bus. It does not take part in the access. Each access it sees carries an address, the id of the requesting client, a read/write flag and a size code. The unit has four watch channels. Each channel holds an inclusive address window, a mask that chooses which operations it watches and a mask that chooses which clients it watches. An access that passes all three filters of a channel is a hit on that channel.

On the first hit a channel records the address, the operation, the size and the id of the client that caused it. It then keeps that record unchanged until software acknowledges the channel. Later hits only add their client to a one-bit-per-client set.

Every hit also sets a pending bit for its channel. A global enable mask selects which pending bits reach the single interrupt output. Software clears a hit with two separate writes: a channel acknowledge, which drops the record, and an interrupt acknowledge, which drops the pending bits named in its data.

Software uses a one-cycle register write port and a combinational read port. Both are indexed by a 3-bit field code and a channel number.

Top module: `bus_watch_unit`

## Requirements
- R1: While reset is asserted and after it is released, every configuration field reads 0, nothing is captured, STATUS reads 0 and `irq_o` is low. Reset is asserted by `rst_n` low and released by the internal synchronizer. A channel at its reset configuration never hits.
- R2: The address test passes when first ≤ address ≤ last, unsigned. Both ends of the window are inclusive, and one below `first` or one above `last` does not pass.
- R3: In the operation mask, bit 0 enables reads (`acc_write`=0) and bit 1 enables writes (`acc_write`=1). An access whose operation is not enabled causes no hit.
- R4: In the client mask, bit i enables client id i. An access from a disabled client causes no hit.
- R5: A hit on a channel holding no record captures the access in the next cycle. HIT_ADDR holds the address and HIT_CLIENTS holds only the bit of the client. HIT_INFO holds bit 0 = captured, bit 1 = write, bits [3:2] = size and bits [7:4] = the client id.
- R6: While a record is held, further hits leave HIT_ADDR and the HIT_INFO fields unchanged and OR their client bit into HIT_CLIENTS.
- R7: Every hit sets the channel's pending bit in the next cycle, whether or not the channel's interrupt is enabled. STATUS holds the masked pending bits in [3:0], the raw pending bits in [7:4] and the enable mask in [11:8]. `irq_o` is high exactly when some masked pending bit is set.
- R8: A write to field 6 clears the pending bit of every channel whose data bit is 1, from the cycle after the write. A hit on that channel in the same cycle keeps the bit set.
- R9: A write to field 4 clears that channel's record from the next cycle (HIT_ADDR, HIT_CLIENTS and HIT_INFO read 0) and leaves the pending bits alone. The next hit captures afresh.
- R10: With `acc_valid` low, no channel hits and no pending bit changes, whatever the other access inputs carry.
- R11: Channels are independent. One access can hit several channels, and a channel with operation mask 0 never hits.
- R12: Write field codes are 0 first, 1 last, 2 operation mask, 3 client mask, 4 channel acknowledge, 5 interrupt enable mask and 6 interrupt acknowledge. Fields 5 and 6 ignore `wr_ch`. Read codes 0 to 3 return the configuration as written. Read codes 4 to 7 return HIT_CLIENTS, HIT_ADDR, HIT_INFO and STATUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_client | input | CID_W | Id of the requesting client |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | SIZE_W | Access size code |
| wr_en | input | 1 | Register write strobe |
| wr_field | input | 3 | Write field code |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_data | input | ADDR_W | Write data |
| rd_field | input | 3 | Read field code |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_data | output | ADDR_W | Read data, combinational |
| irq_o | output | 1 | Interrupt, OR of masked pending bits |

## Verification
The bench builds the unit with its defaults: four channels, 32-bit addresses, 4-bit client ids (16 clients) and a 2-bit size. Four channels are enough to give overlapping windows, so one access can hit two channels at once, and to leave one channel with an operation mask of 0. Sixteen clients let the clients set grow from a single bit to several. The 32-bit window lets the bench probe one address below, at, and one above each edge of a window.

// File: rtl/bwu_pkg.sv
`timescale 1ns/1ps
package bwu_pkg;

  typedef enum logic [2:0] {
    WF_FIRST    = 3'd0,
    WF_LAST     = 3'd1,
    WF_OPS      = 3'd2,
    WF_CLIENTS  = 3'd3,
    WF_CH_ACK   = 3'd4,
    WF_INT_MASK = 3'd5,
    WF_INT_ACK  = 3'd6,
    WF_NONE     = 3'd7
  } wr_field_e;

  typedef enum logic [2:0] {
    RF_FIRST       = 3'd0,
    RF_LAST        = 3'd1,
    RF_OPS         = 3'd2,
    RF_CLIENTS     = 3'd3,
    RF_HIT_CLIENTS = 3'd4,
    RF_HIT_ADDR    = 3'd5,
    RF_HIT_INFO    = 3'd6,
    RF_STATUS      = 3'd7
  } rd_field_e;

  localparam int OP_RD_BIT = 0;
  localparam int OP_WR_BIT = 1;

endpackage

// File: rtl/bwu_match.sv
`timescale 1ns/1ps
module bwu_match #(
  parameter int ADDR_W = 32,
  parameter int CID_W  = 4,
  localparam int NCLI  = 1 << CID_W
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CID_W-1:0]  acc_client,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [1:0]        op_en,
  input  logic [NCLI-1:0]   cli_en,
  output logic              hit
);
  import bwu_pkg::*;

  logic in_window;
  logic op_ok;
  logic cli_ok;

  always_comb begin
    in_window = (acc_addr >= lo_addr) && (acc_addr <= hi_addr);
    op_ok     = acc_write ? op_en[OP_WR_BIT] : op_en[OP_RD_BIT];
    cli_ok    = cli_en[acc_client];
    hit       = acc_valid && in_window && op_ok && cli_ok;
  end

endmodule

// File: rtl/bwu_channel.sv
`timescale 1ns/1ps
module bwu_channel #(
  parameter int ADDR_W = 32,
  parameter int CID_W  = 4,
  parameter int SIZE_W = 2,
  localparam int NCLI  = 1 << CID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CID_W-1:0]  acc_client,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              cfg_sel,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              ch_ack,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q,
  output logic [1:0]        ops_q,
  output logic [NCLI-1:0]   cmask_q,
  output logic              hit,
  output logic              capt_q,
  output logic [NCLI-1:0]   sclients_q,
  output logic [ADDR_W-1:0] saddr_q,
  output logic              swrite_q,
  output logic [SIZE_W-1:0] ssize_q,
  output logic [CID_W-1:0]  sfirst_q
);
  import bwu_pkg::*;

  wr_field_e fld;
  logic en_first, en_last, en_ops, en_cmask;

  assign fld      = wr_field_e'(cfg_field);
  assign en_first = cfg_sel && (fld == WF_FIRST);
  assign en_last  = cfg_sel && (fld == WF_LAST);
  assign en_ops   = cfg_sel && (fld == WF_OPS);
  assign en_cmask = cfg_sel && (fld == WF_CLIENTS);

  // configuration registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      ops_q   <= '0;
      cmask_q <= '0;
    end else begin
      if (en_first) first_q <= cfg_data;
      if (en_last)  last_q  <= cfg_data;
      if (en_ops)   ops_q   <= cfg_data[1:0];
      if (en_cmask) cmask_q <= cfg_data[NCLI-1:0];
    end
  end

  bwu_match #(.ADDR_W(ADDR_W), .CID_W(CID_W)) u_match (
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_client(acc_client),
    .acc_write (acc_write),
    .lo_addr   (first_q),
    .hi_addr   (last_q),
    .op_en     (ops_q),
    .cli_en    (cmask_q),
    .hit       (hit)
  );

  // snapshot next state
  logic              capt_n;
  logic [NCLI-1:0]   sclients_n;
  logic [ADDR_W-1:0] saddr_n;
  logic              swrite_n;
  logic [SIZE_W-1:0] ssize_n;
  logic [CID_W-1:0]  sfirst_n;
  logic [NCLI-1:0]   cli_bit;
  logic              held;
  logic              snap_en;

  always_comb begin
    cli_bit    = NCLI'(1) << acc_client;
    held       = capt_q && !ch_ack;
    capt_n     = capt_q;
    sclients_n = sclients_q;
    saddr_n    = saddr_q;
    swrite_n   = swrite_q;
    ssize_n    = ssize_q;
    sfirst_n   = sfirst_q;
    if (ch_ack) begin
      capt_n     = 1'b0;
      sclients_n = '0;
      saddr_n    = '0;
      swrite_n   = 1'b0;
      ssize_n    = '0;
      sfirst_n   = '0;
    end
    if (hit) begin
      if (held) begin
        sclients_n = sclients_q | cli_bit;
      end else begin
        capt_n     = 1'b1;
        sclients_n = cli_bit;
        saddr_n    = acc_addr;
        swrite_n   = acc_write;
        ssize_n    = acc_size;
        sfirst_n   = acc_client;
      end
    end
    snap_en = hit || ch_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q     <= 1'b0;
      sclients_q <= '0;
      saddr_q    <= '0;
      swrite_q   <= 1'b0;
      ssize_q    <= '0;
      sfirst_q   <= '0;
    end else if (snap_en) begin
      capt_q     <= capt_n;
      sclients_q <= sclients_n;
      saddr_q    <= saddr_n;
      swrite_q   <= swrite_n;
      ssize_q    <= ssize_n;
      sfirst_q   <= sfirst_n;
    end
  end

endmodule

// File: rtl/bwu_irq.sv
`timescale 1ns/1ps
module bwu_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_v,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic              irq_o
);

  logic [NUM_CH-1:0] pend_n;
  logic [NUM_CH-1:0] clr_bits;
  logic              pend_en;

  always_comb begin
    clr_bits = ack_we ? wbits : '0;
    pend_n   = (pend_q & ~clr_bits) | hit_v;
    pend_en  = ack_we || (|hit_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wbits;
    end
  end

  assign irq_o = |(pend_q & mask_q);

endmodule

// File: rtl/bus_watch_unit.sv
`timescale 1ns/1ps
module bus_watch_unit #(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 32,
  parameter int CID_W   = 4,
  parameter int SIZE_W  = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CID_W-1:0]  acc_client,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              wr_en,
  input  logic [2:0]        wr_field,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [2:0]        rd_field,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] rd_data,
  output logic              irq_o
);
  import bwu_pkg::*;

  localparam int NCLI = 1 << CID_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wr_field_e wfld;
  rd_field_e rfld;
  logic      mask_we, iack_we;

  assign wfld    = wr_field_e'(wr_field);
  assign rfld    = rd_field_e'(rd_field);
  assign mask_we = wr_en && (wfld == WF_INT_MASK);
  assign iack_we = wr_en && (wfld == WF_INT_ACK);

  logic [NUM_CH-1:0][ADDR_W-1:0] first_v, last_v, saddr_v;
  logic [NUM_CH-1:0][1:0]        ops_v;
  logic [NUM_CH-1:0][NCLI-1:0]   cmask_v, sclients_v;
  logic [NUM_CH-1:0][SIZE_W-1:0] ssize_v;
  logic [NUM_CH-1:0][CID_W-1:0]  sfirst_v;
  logic [NUM_CH-1:0]             hit_v, capt_v, swrite_v, ack_v, sel_v;
  logic [NUM_CH-1:0]             pend_q, mask_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel_v[c] = wr_en && (int'(wr_ch) == c);
    assign ack_v[c] = sel_v[c] && (wfld == WF_CH_ACK);

    bwu_channel #(.ADDR_W(ADDR_W), .CID_W(CID_W), .SIZE_W(SIZE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_client(acc_client),
      .acc_write (acc_write),
      .acc_size  (acc_size),
      .cfg_sel   (sel_v[c]),
      .cfg_field (wr_field),
      .cfg_data  (wr_data),
      .ch_ack    (ack_v[c]),
      .first_q   (first_v[c]),
      .last_q    (last_v[c]),
      .ops_q     (ops_v[c]),
      .cmask_q   (cmask_v[c]),
      .hit       (hit_v[c]),
      .capt_q    (capt_v[c]),
      .sclients_q(sclients_v[c]),
      .saddr_q   (saddr_v[c]),
      .swrite_q  (swrite_v[c]),
      .ssize_q   (ssize_v[c]),
      .sfirst_q  (sfirst_v[c])
    );
  end

  bwu_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .hit_v  (hit_v),
    .mask_we(mask_we),
    .ack_we (iack_we),
    .wbits  (wr_data[NUM_CH-1:0]),
    .pend_q (pend_q),
    .mask_q (mask_q),
    .irq_o  (irq_o)
  );

  // combinational read port
  logic ch_ok;
  assign ch_ok = int'(rd_ch) < NUM_CH;

  always_comb begin
    rd_data = '0;
    if (rfld == RF_STATUS) begin
      rd_data = ADDR_W'({mask_q, pend_q, pend_q & mask_q});
    end else if (ch_ok) begin
      case (rfld)
        RF_FIRST:       rd_data = first_v[rd_ch];
        RF_LAST:        rd_data = last_v[rd_ch];
        RF_OPS:         rd_data = ADDR_W'(ops_v[rd_ch]);
        RF_CLIENTS:     rd_data = ADDR_W'(cmask_v[rd_ch]);
        RF_HIT_CLIENTS: rd_data = ADDR_W'(sclients_v[rd_ch]);
        RF_HIT_ADDR:    rd_data = saddr_v[rd_ch];
        RF_HIT_INFO:    rd_data = ADDR_W'({sfirst_v[rd_ch], ssize_v[rd_ch],
                                           swrite_v[rd_ch], capt_v[rd_ch]});
        default:        rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/bwu_checker.sv
`timescale 1ns/1ps
module bwu_checker #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int NCLI   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic [ADDR_W-1:0]             acc_addr,
  input logic                          wr_en,
  input logic                          iack_we,
  input logic [NUM_CH-1:0]             iack_bits,
  input logic [NUM_CH-1:0]             hit_v,
  input logic [NUM_CH-1:0]             capt_v,
  input logic [NUM_CH-1:0]             ack_v,
  input logic [NUM_CH-1:0]             pend_q,
  input logic [NUM_CH-1:0][ADDR_W-1:0] saddr_v,
  input logic [NUM_CH-1:0][NCLI-1:0]   sclients_v
);

  // R10: no hit without a valid access
  assert_no_hit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit_v == '0));

  // R10: pending bits hold when neither an access nor a write is present
  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !wr_en) |=> $stable(pend_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_hit_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_v[c] |=> pend_q[c]);

    assert_iack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_we && iack_bits[c] && !hit_v[c]) |=> !pend_q[c]);

    assert_first_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[c] && !capt_v[c]) |=> (capt_v[c] && saddr_v[c] == $past(acc_addr)));

    assert_frozen_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (capt_v[c] && !ack_v[c]) |=> (capt_v[c] && $stable(saddr_v[c])));

    assert_clients_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (capt_v[c] && !ack_v[c]) |=>
        ((sclients_v[c] & $past(sclients_v[c])) == $past(sclients_v[c])));

    assert_chack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_v[c] && !hit_v[c]) |=> !capt_v[c]);
  end

endmodule

bind bus_watch_unit bwu_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .NCLI(1 << CID_W)
) u_bwu_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .wr_en     (wr_en),
  .iack_we   (iack_we),
  .iack_bits (wr_data[NUM_CH-1:0]),
  .hit_v     (hit_v),
  .capt_v    (capt_v),
  .ack_v     (ack_v),
  .pend_q    (pend_q),
  .saddr_v   (saddr_v),
  .sclients_v(sclients_v)
);

// File: tb/bus_watch_unit_test.sv
`timescale 1ns/1ps
module bus_watch_unit_test;

  localparam int NUM_CH = 4;
  localparam int ADDR_W = 32;
  localparam int CID_W  = 4;
  localparam int SIZE_W = 2;

  // read codes
  localparam logic [2:0] R_FIRST = 3'd0, R_LAST = 3'd1, R_OPS = 3'd2,
                         R_CLI = 3'd3, R_HCLI = 3'd4, R_HADDR = 3'd5,
                         R_HINFO = 3'd6, R_STAT = 3'd7;
  // write codes
  localparam logic [2:0] W_FIRST = 3'd0, W_LAST = 3'd1, W_OPS = 3'd2,
                         W_CLI = 3'd3, W_CHACK = 3'd4, W_MASK = 3'd5,
                         W_IACK = 3'd6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [CID_W-1:0]  acc_client;
  logic              acc_write;
  logic [SIZE_W-1:0] acc_size;
  logic              wr_en;
  logic [2:0]        wr_field;
  logic [1:0]        wr_ch;
  logic [ADDR_W-1:0] wr_data;
  logic [2:0]        rd_field;
  logic [1:0]        rd_ch;
  logic [ADDR_W-1:0] rd_data;
  logic              irq_o;

  always #2 clk = ~clk;

  bus_watch_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CID_W(CID_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_client(acc_client), .acc_write(acc_write), .acc_size(acc_size),
    .wr_en(wr_en), .wr_field(wr_field), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_field(rd_field), .rd_ch(rd_ch), .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [2:0]  fld;
    logic [1:0]  ch;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // monitor: pops expectations and compares them away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        rd_field = it.fld;
        rd_ch    = it.ch;
        #0.05;
        act = it.is_irq ? {31'b0, irq_o} : rd_data;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [2:0] f, input logic [1:0] c,
                        input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.fld = f; it.ch = c; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.fld = R_STAT; it.ch = 2'd0; it.exp = {31'b0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    @(posedge clk); #1;
  endtask

  // one cycle of stimulus; caller sits at posedge+1
  task automatic step(input bit va, input logic [31:0] a, input logic [3:0] cl,
                      input bit w, input logic [1:0] sz,
                      input bit we, input logic [2:0] f, input logic [1:0] c,
                      input logic [31:0] d);
    acc_valid = va; acc_addr = a; acc_client = cl; acc_write = w; acc_size = sz;
    wr_en = we; wr_field = f; wr_ch = c; wr_data = d;
    @(posedge clk); #1;
    acc_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [3:0] cl,
                     input bit w, input logic [1:0] sz);
    step(1'b1, a, cl, w, sz, 1'b0, 3'd0, 2'd0, 32'd0);
  endtask

  task automatic regw(input logic [2:0] f, input logic [1:0] c, input logic [31:0] d);
    step(1'b0, 32'd0, 4'd0, 1'b0, 2'd0, 1'b1, f, c, d);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = 0; acc_client = 0; acc_write = 0; acc_size = 0;
    wr_en = 0; wr_field = 0; wr_ch = 0; wr_data = 0; rd_field = 0; rd_ch = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    exp_rd(R_STAT, 0, 32'h0, "R1 status after reset");
    exp_rd(R_FIRST, 0, 32'h0, "R1 first after reset");
    exp_rd(R_HINFO, 0, 32'h0, "R1 hit info after reset");
    exp_irq(1'b0, "R1 irq after reset");
    drain();

    // configuration
    regw(W_FIRST, 0, 32'h1000); regw(W_LAST, 0, 32'h10FF);
    regw(W_OPS, 0, 32'h2);      regw(W_CLI, 0, 32'h28);
    regw(W_FIRST, 1, 32'h1080); regw(W_LAST, 1, 32'h2000);
    regw(W_OPS, 1, 32'h3);      regw(W_CLI, 1, 32'hFFFF);
    regw(W_FIRST, 2, 32'h4000); regw(W_LAST, 2, 32'h4000);
    regw(W_OPS, 2, 32'h1);      regw(W_CLI, 2, 32'h80);
    exp_rd(R_FIRST, 0, 32'h1000, "R12 first readback");
    exp_rd(R_LAST, 1, 32'h2000, "R12 last readback");
    exp_rd(R_OPS, 2, 32'h1, "R12 ops readback");
    exp_rd(R_CLI, 0, 32'h28, "R12 clients readback");
    drain();

    acc(32'h1000, 4'd3, 1'b0, 2'd0);
    exp_rd(R_STAT, 0, 32'h0, "R3 read filtered by write-only channel");
    drain();
    acc(32'h0FFF, 4'd3, 1'b1, 2'd0);
    exp_rd(R_STAT, 0, 32'h0, "R2 first-1 outside window");
    drain();
    acc(32'h1000, 4'd4, 1'b1, 2'd0);
    exp_rd(R_STAT, 0, 32'h0, "R4 disabled client ignored");
    drain();

    acc(32'h1000, 4'd3, 1'b1, 2'd2);
    exp_rd(R_HADDR, 0, 32'h1000, "R5 captured address");
    exp_rd(R_HINFO, 0, 32'h3B, "R5 captured info");
    exp_rd(R_HCLI, 0, 32'h8, "R5 captured clients");
    exp_rd(R_STAT, 0, 32'h10, "R7 pending with mask off");
    exp_irq(1'b0, "R7 irq masked");
    drain();

    regw(W_MASK, 0, 32'h1);
    exp_rd(R_STAT, 0, 32'h111, "R7 status with mask on");
    exp_irq(1'b1, "R7 irq raised");
    drain();

    acc(32'h10FF, 4'd5, 1'b1, 2'd1);
    exp_rd(R_HADDR, 0, 32'h1000, "R6 address frozen");
    exp_rd(R_HINFO, 0, 32'h3B, "R6 info frozen");
    exp_rd(R_HCLI, 0, 32'h28, "R6 client ORed (R2 last inclusive)");
    exp_rd(R_HINFO, 1, 32'h57, "R11 second channel captured");
    exp_rd(R_STAT, 0, 32'h131, "R11 both pending");
    drain();

    acc(32'h1100, 4'd3, 1'b1, 2'd0);
    exp_rd(R_HCLI, 0, 32'h28, "R2 last+1 outside window");
    exp_rd(R_HCLI, 1, 32'h28, "R6 channel1 clients grow");
    exp_rd(R_HADDR, 1, 32'h10FF, "R6 channel1 address frozen");
    drain();

    regw(W_IACK, 3, 32'h1);
    exp_rd(R_STAT, 0, 32'h120, "R8 pending cleared");
    exp_irq(1'b0, "R8 irq dropped");
    exp_rd(R_HINFO, 0, 32'h3B, "R8 record kept after int ack");
    drain();

    regw(W_CHACK, 0, 32'h0);
    exp_rd(R_HINFO, 0, 32'h0, "R9 info cleared");
    exp_rd(R_HCLI, 0, 32'h0, "R9 clients cleared");
    exp_rd(R_HADDR, 0, 32'h0, "R9 address cleared");
    exp_rd(R_STAT, 0, 32'h120, "R9 pending untouched");
    drain();

    acc(32'h1010, 4'd5, 1'b1, 2'd0);
    exp_rd(R_HADDR, 0, 32'h1010, "R9 fresh capture address");
    exp_rd(R_HINFO, 0, 32'h53, "R9 fresh capture info");
    exp_rd(R_HCLI, 0, 32'h20, "R9 fresh capture clients");
    exp_rd(R_STAT, 0, 32'h131, "R7 pending again");
    drain();

    step(1'b1, 32'h1020, 4'd3, 1'b1, 2'd0, 1'b1, W_IACK, 2'd0, 32'h1);
    exp_rd(R_STAT, 0, 32'h131, "R8 hit wins over ack");
    exp_rd(R_HCLI, 0, 32'h28, "R6 clients after simultaneous hit");
    drain();

    acc(32'h4000, 4'd7, 1'b1, 2'd3);
    exp_rd(R_STAT, 0, 32'h131, "R3 write filtered by read-only channel");
    drain();
    acc(32'h4000, 4'd7, 1'b0, 2'd3);
    exp_rd(R_HINFO, 2, 32'h7D, "R3 read captured on single-address window");
    exp_rd(R_STAT, 0, 32'h171, "R11 channel2 pending, channel3 never");
    drain();

    regw(W_IACK, 0, 32'h4);
    exp_rd(R_STAT, 0, 32'h131, "R8 channel2 pending cleared");
    drain();
    step(1'b0, 32'h4000, 4'd7, 1'b0, 2'd3, 1'b0, 3'd0, 2'd0, 32'h0);
    exp_rd(R_STAT, 0, 32'h131, "R10 invalid access ignored");
    exp_rd(R_HCLI, 2, 32'h80, "R10 clients unchanged");
    drain();

    regw(W_MASK, 2, 32'h0);
    exp_rd(R_STAT, 0, 32'h030, "R7 mask cleared");
    exp_irq(1'b0, "R7 irq low with mask off");
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule